// File: doc/BRIEF.md
# UART Interrupt Pending and Mask Unit

This block gathers the four interrupt sources of a serial port into one level-sensitive interrupt line. Every source has a sticky bit in a source-pending register. The receive, error, transmit and modem logic set these bits with single-cycle pulses. A mask register hides chosen sources. The pending view is the source-pending register with the masked bits removed, and the interrupt line is high whenever that view is non-zero.

Software clears sources by writing ones, either to the source-pending register or to the pending view. Both clear the sticky source bit. The transmit source has two further set paths:
- A pulse reports that a transmit write has completed.
- In FIFO mode, a level rule holds the bit set for as long as the transmit FIFO count is at or below a threshold taken from a 3-bit trigger code.

The block moves no data stream. All pins are plain control and status signals, so there is no valid/ready handshake and no back-pressure. Register state is shown directly on output pins.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the source-pending bits, mask bits and pending bits are all zero, and `irq_o` is low.
- R2: Bit positions are receive = 0, error = 1, transmit = 2 and modem = 3. A one on `src_set_i[k]` sets source-pending bit k on the next clock edge. The bit then stays set until software clears it.
- R3: `pnd_o` always equals `src_pnd_o & ~mask_o`. `irq_o` is high exactly when `pnd_o` is non-zero.
- R4: A write with `wr_off_i` = 2 loads `wr_data_i` into the mask. The new mask appears in `mask_o`, `pnd_o` and `irq_o` on the next clock edge.
- R5: A write with `wr_off_i` = 1 (the pending view) clears every source-pending bit where `wr_data_i` is one. This happens even when that bit is masked.
- R6: A write with `wr_off_i` = 0 (source-pending) clears every source-pending bit where `wr_data_i` is one. Bits written with zero are left unchanged.
- R7: If a set (from any set path) and a clear reach the same bit in the same cycle, the bit is set after the edge.
- R8: While `fifo_en_i` is high and `tx_cnt_i` <= 2 * `tx_trig_i`, source-pending bit 2 is forced set at every edge. A clear cannot remove it while the condition holds.
- R9: While `fifo_en_i` is low, the transmit level rule has no effect, whatever the count and trigger values.
- R10: A pulse on `tx_done_i` sets source-pending bit 2 at the next edge. This does not depend on `fifo_en_i`.
- R11: A write with `wr_off_i` = 3 changes neither the source-pending bits nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set_i | input | 4 | Source set pulses (rx, error, tx, modem) |
| tx_done_i | input | 1 | Pulse: a transmit write has completed |
| fifo_en_i | input | 1 | FIFO mode enable |
| tx_trig_i | input | 3 | Transmit trigger code (threshold = code * 2) |
| tx_cnt_i | input | 5 | Transmit FIFO fill count |
| wr_en_i | input | 1 | Register write strobe |
| wr_off_i | input | 2 | Register select: 0 source-pending, 1 pending, 2 mask, 3 unused |
| wr_data_i | input | 4 | Write data, one bit per source |
| src_pnd_o | output | 4 | Source-pending register |
| pnd_o | output | 4 | Masked pending view |
| mask_o | output | 4 | Mask register |
| irq_o | output | 1 | Interrupt line |

## Verification
Every stimulus reaches the registered state after exactly one clock edge. Set pulses, the level rule, clears and mask loads all become visible in `src_pnd_o` and `mask_o` after that edge. `pnd_o` and `irq_o` are combinational from those two registers, so they follow in the same cycle with no further delay.

The bench drives inputs on the falling edge and advances its reference model at the rising edge. It compares all four outputs on the next falling edge, which is exactly one edge after the stimulus. Directed steps cover the corner cases first, then random stimulus is compared in the same way.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NSRC = 4;

  localparam int unsigned SRC_RX  = 0;
  localparam int unsigned SRC_ERR = 1;
  localparam int unsigned SRC_TX  = 2;
  localparam int unsigned SRC_MDM = 3;

  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_PND  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/uart_irq_src_reg.sv
module uart_irq_src_reg #(
  parameter int unsigned NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_i,
  input  logic [NB-1:0] clr_i,
  output logic [NB-1:0] spnd_q
);
  for (genvar g = 0; g < NB; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          spnd_q[g] <= 1'b0;
      else if (set_i[g])   spnd_q[g] <= 1'b1;
      else if (clr_i[g])   spnd_q[g] <= 1'b0;
    end

    // R7 / R2: a set always lands, even against a clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> spnd_q[g]);
    // R6: a lone clear removes the bit
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !spnd_q[g]);
    // R2: bit is sticky without a clear
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (spnd_q[g] && !clr_i[g]) |=> spnd_q[g]);
  end
endmodule

// File: rtl/uart_irq_tx_level.sv
module uart_irq_tx_level #(
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned TRIG_W = 3
) (
  input  logic              en_i,
  input  logic [TRIG_W-1:0] trig_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              low_o
);
  localparam int unsigned THR_W = TRIG_W + 1;
  localparam int unsigned CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CMP_W-1:0] cnt_x, thr_x;

  always_comb begin
    cnt_x = CMP_W'(cnt_i);
    thr_x = CMP_W'({trig_i, 1'b0});
    low_o = en_i && (cnt_x <= thr_x);
  end
endmodule

// File: rtl/uart_irq_mask_reg.sv
module uart_irq_mask_reg #(
  parameter int unsigned NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [NB-1:0] data_i,
  output logic [NB-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (wr_i) mask_q <= data_i;
  end

  p_mask_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (mask_q == $past(data_i)));
  p_mask_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(mask_q));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned TRIG_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        src_set_i,
  input  logic              tx_done_i,
  input  logic              fifo_en_i,
  input  logic [TRIG_W-1:0] tx_trig_i,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_off_i,
  input  logic [3:0]        wr_data_i,
  output logic [3:0]        src_pnd_o,
  output logic [3:0]        pnd_o,
  output logic [3:0]        mask_o,
  output logic              irq_o
);
  import uart_irq_pkg::*;

  localparam int unsigned NB = NSRC;

  logic          tx_low;
  logic [NB-1:0] set_all, clr_all;
  logic          wr_mask;
  reg_sel_e      sel;

  uart_irq_tx_level #(.CNT_W(CNT_W), .TRIG_W(TRIG_W)) u_lvl (
    .en_i  (fifo_en_i),
    .trig_i(tx_trig_i),
    .cnt_i (tx_cnt_i),
    .low_o (tx_low)
  );

  always_comb begin
    sel             = reg_sel_e'(wr_off_i);
    set_all         = src_set_i;
    set_all[SRC_TX] = src_set_i[SRC_TX] | tx_done_i | tx_low;
    clr_all         = (wr_en_i && (sel == SEL_SRC || sel == SEL_PND)) ? wr_data_i : '0;
    wr_mask         = wr_en_i && (sel == SEL_MASK);
  end

  uart_irq_src_reg #(.NB(NB)) u_src (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_all),
    .clr_i (clr_all),
    .spnd_q(src_pnd_o)
  );

  uart_irq_mask_reg #(.NB(NB)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_i  (wr_mask),
    .data_i(wr_data_i),
    .mask_q(mask_o)
  );

  assign pnd_o = src_pnd_o & ~mask_o;
  assign irq_o = |pnd_o;

  // R8: level rule keeps tx source set
  p_tx_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_low |=> src_pnd_o[SRC_TX]);
  // R10: completed transmit write sets tx source
  p_tx_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_i |=> src_pnd_o[SRC_TX]);
  // R3: interrupt only with some source pending
  p_irq_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (src_pnd_o != '0));
  // R11: unused offset leaves source bits alone when nothing sets
  p_rsvd_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_off_i == 2'd3) |=> ((src_pnd_o & ~$past(src_pnd_o)) == '0 || $past(set_all) != '0));
endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_set = '0;
  logic       tx_done = 1'b0;
  logic       fifo_en = 1'b0;
  logic [2:0] tx_trig = '0;
  logic [4:0] tx_cnt = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_off = '0;
  logic [3:0] wr_data = '0;
  logic [3:0] src_pnd, pnd, mask;
  logic       irq;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 0;

  int m_sp   = 0;
  int m_mask = 0;

  always #4 clk = ~clk;

  uart_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_set_i(src_set), .tx_done_i(tx_done),
    .fifo_en_i(fifo_en), .tx_trig_i(tx_trig), .tx_cnt_i(tx_cnt),
    .wr_en_i(wr_en), .wr_off_i(wr_off), .wr_data_i(wr_data),
    .src_pnd_o(src_pnd), .pnd_o(pnd), .mask_o(mask), .irq_o(irq)
  );

  task automatic compare(string tag);
    int e_pnd;
    int e_irq;
    e_pnd = m_sp & ~m_mask & 15;
    e_irq = (e_pnd != 0) ? 1 : 0;
    vectors++;
    if (int'(src_pnd) != m_sp || int'(mask) != m_mask ||
        int'(pnd) != e_pnd || int'(irq) != e_irq) begin
      errors++;
      $display("FAIL %s: got sp=%h mask=%h pnd=%h irq=%0d exp sp=%h mask=%h pnd=%h irq=%0d",
               tag, src_pnd, mask, pnd, irq, m_sp, m_mask, e_pnd, e_irq);
    end
  endtask

  task automatic step(input logic [3:0] s, input logic td, input logic en,
                      input logic [2:0] tr, input logic [4:0] c,
                      input logic w, input logic [1:0] o, input logic [3:0] d,
                      input string tag);
    int set;
    int clr;
    src_set = s; tx_done = td; fifo_en = en; tx_trig = tr; tx_cnt = c;
    wr_en = w; wr_off = o; wr_data = d;
    @(posedge clk);
    set = int'(s);
    if (td) set |= 4;
    if (en && int'(c) <= 2 * int'(tr)) set |= 4;
    clr = (w && (o == 2'd0 || o == 2'd1)) ? int'(d) : 0;
    m_sp = ((m_sp & ~clr) | set) & 15;
    if (w && o == 2'd2) m_mask = int'(d);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");
    // R2: each source bit
    step(4'b0001, 0, 0, 0, 0, 0, 0, 0, "R2 rx");
    step(4'b0010, 0, 0, 0, 0, 0, 0, 0, "R2 err");
    step(4'b1000, 0, 0, 0, 0, 0, 0, 0, "R2 modem");
    step(4'b0000, 0, 0, 0, 0, 0, 0, 0, "R2 sticky");
    // R4 / R3: mask hides bits
    step(4'b0000, 0, 0, 0, 0, 1, 2, 4'b1011, "R4 mask load");
    step(4'b0000, 0, 0, 0, 0, 1, 2, 4'b0001, "R3 partial mask");
    // R5: pending write clears masked source too
    step(4'b0000, 0, 0, 0, 0, 1, 1, 4'b0001, "R5 clear via pending");
    // R6: source write clears chosen bits
    step(4'b0000, 0, 0, 0, 0, 1, 0, 4'b0010, "R6 clear source");
    // R7: set beats clear
    step(4'b1000, 0, 0, 0, 0, 1, 0, 4'b1000, "R7 set vs clear");
    step(4'b0000, 0, 0, 0, 0, 1, 0, 4'b1111, "R6 clear all");
    // R10: tx done, FIFO off
    step(4'b0000, 1, 0, 0, 0, 0, 0, 0, "R10 tx done");
    step(4'b0000, 0, 0, 0, 0, 1, 1, 4'b0100, "R5 clear tx");
    // R9: level rule disabled
    step(4'b0000, 0, 0, 3'd7, 5'd0, 0, 0, 0, "R9 fifo off");
    // R8: boundary count == threshold, then above
    step(4'b0000, 0, 1, 3'd3, 5'd6, 0, 0, 0, "R8 at threshold");
    step(4'b0000, 0, 1, 3'd3, 5'd6, 1, 0, 4'b0100, "R8 clear blocked");
    step(4'b0000, 0, 1, 3'd3, 5'd7, 1, 0, 4'b0100, "R8 above threshold");
    step(4'b0000, 0, 1, 3'd0, 5'd0, 0, 0, 0, "R8 code zero count zero");
    step(4'b0000, 0, 1, 3'd0, 5'd1, 1, 1, 4'b0100, "R8 code zero count one");
    step(4'b0000, 0, 1, 3'd7, 5'd16, 0, 0, 0, "R8 full fifo above 14");
    // R11: unused offset
    step(4'b0101, 0, 0, 0, 0, 0, 0, 0, "R2 set two");
    step(4'b0000, 0, 0, 0, 0, 1, 3, 4'b1111, "R11 unused offset");
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] rs;
      rs = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'b0000;
      step(rs, 1'($urandom_range(0, 7) == 0), 1'($urandom), 3'($urandom),
           5'($urandom_range(0, 16)), 1'($urandom), 2'($urandom), 4'($urandom),
           "R3 random");
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule